// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block chooses which analog input a multiplexed converter samples next, and stores the converted words. A 16-bit select mask marks the primary-multiplexer inputs to be scanned. When scanning is on, the primary channel steps upward through the marked inputs and wraps back to the lowest marked input after the highest. When alternate mode is on, every primary sample is followed by one sample of a fixed secondary input. The combination interleaves a scanned list with one fixed reference channel. For a mask with bits 3, 4 and 5 set and secondary input 6, the buffer fills as 3, 6, 4, 6, 5, 6, 3, 6.

The converter is outside the block. The block presents the channel number on `ch_sel` and waits. When the converter returns a one-cycle `conv_done` strobe with its result word, the block writes that word into a 16-word result buffer at a rising slot index. It then moves to the next channel. After a programmed number of samples, the index returns to slot 0 and `irq` pulses for one cycle. Configuration arrives on plain input ports and must be held steady while a conversion is outstanding.

Top module: `adc_scan_seq`

## Requirements
- R1: With `scan_en`=1 and a non-zero `scan_mask`, each primary conversion uses the next input whose mask bit is set, in ascending order. After the highest set bit, the sequence wraps to the lowest set bit.
- R2: With `alt_en`=1, conversions alternate between the primary channel and `sec_ch`, starting with the primary channel after reset.
- R3: With both `scan_en` and `alt_en` set, the primary channel advances only on primary conversions, and every secondary conversion uses `sec_ch`. Mask 0x0038 with `sec_ch`=6 yields 3,6,4,6,5,6,3,6.
- R4: The highest set mask bit is always converted, including bit 15. None of the enabled entries is ever skipped.
- R5: With `scan_en`=0, every primary conversion uses `pri_fix_ch`.
- R6: With `scan_en`=1 and `scan_mask`=0, every primary conversion uses `pri_fix_ch`.
- R7: The k-th conversion since the last wrap writes `conv_result` to buffer slot k, starting at slot 0. Any slot can be read combinationally through `rd_addr`/`rd_data`.
- R8: The conversion that writes slot `smpi_m1` returns the slot index to 0. `irq` is high for exactly the one cycle that follows that `conv_done` clock edge, and is low at all other times. The number of samples per interrupt is `smpi_m1`+1.
- R9: While `rst` is high at a clock edge, the scan position, the alternate phase and the slot index are cleared and `irq` is cleared. The first conversion after reset uses the lowest set mask bit, or the primary channel, and writes slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Scan the masked primary inputs |
| alt_en | input | 1 | Interleave the secondary input after each primary sample |
| scan_mask | input | 16 | Primary inputs taking part in the scan |
| pri_fix_ch | input | 4 | Primary channel when no scan applies |
| sec_ch | input | 4 | Secondary channel for alternate mode |
| smpi_m1 | input | 4 | Samples per interrupt minus one |
| conv_done | input | 1 | One-cycle strobe: conversion of `ch_sel` finished |
| conv_result | input | 12 | Result word accompanying `conv_done` |
| ch_sel | output | 4 | Channel to convert next |
| irq | output | 1 | One-cycle interrupt pulse after a full sample group |
| rd_addr | input | 4 | Buffer read slot |
| rd_data | output | 12 | Buffer contents at `rd_addr` |

## Verification
A wrong scan position appears on `ch_sel` before the very next conversion. Because of this, the bench compares the channel before every strobe, not only the buffered data. A dropped or extra phase toggle puts the secondary channel in a primary slot within one conversion. That error then stays shifted for the rest of the run. A slot index that drifts shows up as an `irq` that is early, late or missing at the group boundary. It also shows up as buffer contents out of order when the slots are read back after the group.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CH_COUNT  = 16;
  localparam int CH_W      = $clog2(CH_COUNT);
  localparam int RES_W     = 12;
  localparam int BUF_DEPTH = 16;
  localparam int BIDX_W    = $clog2(BUF_DEPTH);

  // Lowest set bit of mask at or above 'from', wrapping past the top.
  // Rotates the mask so 'from' lands at bit 0, then takes the lowest set bit.
  // CH_COUNT is a power of two, so the final add wraps for free.
  function automatic logic [CH_W-1:0] scan_pick(input logic [CH_COUNT-1:0] mask,
                                                input logic [CH_W-1:0]     from);
    logic [2*CH_COUNT-1:0] dbl;
    logic [CH_COUNT-1:0]   rot;
    logic [CH_W-1:0]       off;
    dbl = {mask, mask};
    rot = dbl[from +: CH_COUNT];
    off = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (rot[i]) off = CH_W'(i);
    end
    return from + off;
  endfunction

  // Index after a write: wraps to zero at the last slot of the group.
  function automatic logic [BIDX_W-1:0] slot_next(input logic [BIDX_W-1:0] idx,
                                                  input logic [BIDX_W-1:0] last);
    return (idx == last) ? '0 : idx + 1'b1;
  endfunction
endpackage

// File: rtl/adc_scan_ptr.sv
module adc_scan_ptr
  import adc_scan_pkg::*;
#(
  parameter int NCH = CH_COUNT,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] mask,
  input  logic           scan_active,
  input  logic           advance,
  output logic [CW-1:0]  cur_ch
);
  logic [CW-1:0] ptr_q;

  assign cur_ch = scan_pick(mask, ptr_q);

  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= '0;
    else if (advance) ptr_q <= cur_ch + 1'b1;
  end

  AST_PICK_IN_MASK: assert property (@(posedge clk) disable iff (rst)
    scan_active |-> mask[cur_ch]);  // R1
  AST_PICK_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (ptr_q == '0));  // R9
endmodule

// File: rtl/adc_buf_ctrl.sv
module adc_buf_ctrl
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [IW-1:0] last_slot,
  output logic [IW-1:0] slot,
  output logic          irq
);
  logic wrap_evt;

  assign wrap_evt = wr_stb && (slot == last_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= wrap_evt;
      if (wr_stb) slot <= slot_next(slot, last_slot);
    end
  end

  AST_IRQ_AT_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq |-> (slot == '0));  // R8
  AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> !irq);  // R8
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(slot));  // R7
  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (slot == '0) && !irq);  // R9
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH,
  parameter int W     = RES_W,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH   = CH_COUNT,
  parameter int RW    = RES_W,
  parameter int DEPTH = BUF_DEPTH,
  localparam int CW   = $clog2(NCH),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scan_en,
  input  logic           alt_en,
  input  logic [NCH-1:0] scan_mask,
  input  logic [CW-1:0]  pri_fix_ch,
  input  logic [CW-1:0]  sec_ch,
  input  logic [IW-1:0]  smpi_m1,
  input  logic           conv_done,
  input  logic [RW-1:0]  conv_result,
  output logic [CW-1:0]  ch_sel,
  output logic           irq,
  input  logic [IW-1:0]  rd_addr,
  output logic [RW-1:0]  rd_data
);
  logic          sec_phase_q;
  logic          is_sec;
  logic          scan_active;
  logic          pri_advance;
  logic [CW-1:0] scan_ch;
  logic [CW-1:0] pri_ch;
  logic [IW-1:0] slot;

  assign scan_active = scan_en && (|scan_mask);
  assign is_sec      = alt_en && sec_phase_q;
  assign pri_advance = conv_done && !is_sec && scan_active;
  assign pri_ch      = scan_active ? scan_ch : pri_fix_ch;
  assign ch_sel      = is_sec ? sec_ch : pri_ch;

  always_ff @(posedge clk) begin
    if (rst)                       sec_phase_q <= 1'b0;
    else if (alt_en && conv_done)  sec_phase_q <= !sec_phase_q;
  end

  adc_scan_ptr #(.NCH(NCH)) u_ptr (
    .clk(clk), .rst(rst), .mask(scan_mask), .scan_active(scan_active),
    .advance(pri_advance), .cur_ch(scan_ch)
  );

  adc_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(conv_done), .last_slot(smpi_m1),
    .slot(slot), .irq(irq)
  );

  adc_result_buf #(.DEPTH(DEPTH), .W(RW)) u_buf (
    .clk(clk), .we(conv_done), .waddr(slot), .wdata(conv_result),
    .raddr(rd_addr), .rdata(rd_data)
  );

  AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (alt_en && conv_done) |=> (sec_phase_q != $past(sec_phase_q)));  // R2
  AST_SEC_FIXED: assert property (@(posedge clk) disable iff (rst)
    (alt_en && sec_phase_q) |-> (ch_sel == sec_ch));  // R3
  AST_PRI_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (!scan_active && !is_sec) |-> (ch_sel == pri_fix_ch));  // R5 R6
  AST_PHASE_RESET: assert property (@(posedge clk)
    rst |=> !sec_phase_q);  // R9
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_en = 1'b0, alt_en = 1'b0;
  logic [15:0] scan_mask = '0;
  logic [3:0]  pri_fix_ch = '0, sec_ch = '0, smpi_m1 = '0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic [3:0]  ch_sel;
  logic        irq;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Reference model state
  int          m_pos;
  bit          m_sec;
  int          m_slot;
  logic [11:0] m_buf [16];
  bit          m_written [16];
  int          seen [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .alt_en(alt_en), .scan_mask(scan_mask),
    .pri_fix_ch(pri_fix_ch), .sec_ch(sec_ch), .smpi_m1(smpi_m1), .conv_done(conv_done),
    .conv_result(conv_result), .ch_sel(ch_sel), .irq(irq), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Walk upward from pos, first enabled entry wins.
  function automatic int model_primary();
    if (!scan_en || scan_mask == 16'h0) return pri_fix_ch;
    for (int k = 0; k < 16; k++)
      if (scan_mask[(m_pos + k) % 16]) return (m_pos + k) % 16;
    return -1;
  endfunction

  function automatic string tag_for();
    if (alt_en && m_sec) return "R3";
    if (!scan_en) return "R5";
    if (scan_mask == 16'h0) return "R6";
    if (alt_en) return "R2";
    return "R1";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    conv_done = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_pos = 0; m_sec = 0; m_slot = 0;
    seen.delete();
    for (int i = 0; i < 16; i++) m_written[i] = 0;
    check("R9", irq, 0, "irq after reset");
    check("R9", ch_sel, model_primary(), "first channel after reset");
  endtask

  task automatic convert(input logic [11:0] res);
    int exp_ch;
    bit exp_irq;
    exp_ch = (alt_en && m_sec) ? int'(sec_ch) : model_primary();
    check(tag_for(), ch_sel, exp_ch, "channel before conversion");
    seen.push_back(ch_sel);
    conv_result = res;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    m_buf[m_slot] = res;
    m_written[m_slot] = 1;
    if (!(alt_en && m_sec) && scan_en && scan_mask != 16'h0) m_pos = (exp_ch + 1) % 16;
    if (alt_en) m_sec = !m_sec;
    exp_irq = (m_slot == int'(smpi_m1));
    m_slot = exp_irq ? 0 : m_slot + 1;
    check("R8", irq, exp_irq, "irq after conversion");
    @(negedge clk);
    check("R8", irq, 0, "irq one cycle only");
  endtask

  task automatic check_buffer();
    for (int i = 0; i < 16; i++) begin
      if (m_written[i]) begin
        rd_addr = 4'(i);
        #1;
        check("R7", rd_data, m_buf[i], $sformatf("slot %0d", i));
      end
    end
  endtask

  task automatic cfg(input bit s, input bit a, input logic [15:0] m,
                     input logic [3:0] p, input logic [3:0] sc, input logic [3:0] n);
    scan_en = s; alt_en = a; scan_mask = m; pri_fix_ch = p; sec_ch = sc; smpi_m1 = n;
  endtask

  initial begin
    int dummy;
    int exp_seq [8] = '{3, 6, 4, 6, 5, 6, 3, 6};
    dummy = $urandom(32'h5eed_0123);

    // Worked interleave example, 8 samples per interrupt
    cfg(1, 1, 16'h0038, 4'd0, 4'd6, 4'd7);
    do_reset();
    for (int i = 0; i < 8; i++) convert(12'(100 + i));
    for (int i = 0; i < 8; i++) check("R3", seen[i], exp_seq[i], "interleave order");
    check_buffer();
    check("R8", m_slot, 0, "group of 8 wrapped");

    // Highest bit 15 must be visited (R4)
    cfg(1, 0, 16'h8001, 4'd0, 4'd0, 4'd15);
    do_reset();
    for (int i = 0; i < 5; i++) convert(12'(i));
    check("R4", seen[1], 15, "bit 15 visited");
    check("R4", seen[2], 0, "wrap after bit 15");

    // Only the top entry enabled
    cfg(1, 1, 16'h8000, 4'd0, 4'd2, 4'd3);
    do_reset();
    for (int i = 0; i < 4; i++) convert(12'(i));
    check("R4", seen[2], 15, "single top entry repeats");

    // Scan off: fixed primary (R5), alternate only (R2)
    cfg(0, 1, 16'hFFFF, 4'd9, 4'd11, 4'd1);
    do_reset();
    for (int i = 0; i < 4; i++) convert(12'(i));
    check("R2", seen[0], 9, "alt starts primary");
    check("R2", seen[1], 11, "alt then secondary");

    // Scan on, empty mask (R6)
    cfg(1, 0, 16'h0000, 4'd12, 4'd0, 4'd0);
    do_reset();
    for (int i = 0; i < 3; i++) convert(12'(i));
    check("R6", seen[2], 12, "empty mask falls back");

    // Random configurations
    for (int t = 0; t < 40; t++) begin
      cfg($urandom_range(0, 1), $urandom_range(0, 1),
          ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'($urandom),
          4'($urandom), 4'($urandom), 4'($urandom));
      do_reset();
      for (int i = 0, n = $urandom_range(1, 40); i < n; i++) convert(12'($urandom));
      check_buffer();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL all watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule